// File: doc/BRIEF.md
# Circular Pass-Window Phase Selector

This block takes the outcome of a sampling-phase sweep and picks the phase to settle on. The input is a pass mask with one bit per phase: bit n set means phase n sampled correctly. The block groups the set bits into runs of neighbouring phases. It picks the widest run and returns the phase three quarters of the way into that run, counted from the run's low end. The top phase and phase 0 count as neighbours. When the run that begins at phase 0 and a run that ends at the top phase are both present, they form one window. That window starts at the lower edge of the top run and continues through the phase-0 run.

A controller first completes its sweep and then pulses `start` with the mask. The block walks the mask one phase per clock. A fixed number of cycles later it raises `done` for one cycle, together with the chosen phase and an error flag. The phase and error outputs keep their values until the next result.

Top module: `phase_window_pick`

## Requirements
- R1: A `start` that is accepted while the block is idle produces exactly one `done` pulse, one cycle long, 17 clock edges later (NPH+1). The edge that samples `start` is edge 0, and `done` is high after edge 17.
- R2: An all-zero mask gives `error`=1 and `phase`=0 with the `done` pulse.
- R3: For a window of count c whose lowest phase is s, the output is s+k, where k = floor(3c/4) - 1 when floor(3c/4) is nonzero and k = 0 otherwise. A full mask (16 passes) is one window from phase 0 and gives phase 11.
- R4: Suppose mask bit 0 and mask bit 15 are both set and the mask is not all ones. Then the run from phase 0 and the run that ends at phase 15 form one window. Its count is the sum of their counts and its elements, in order, are the top run followed by the phase-0 run. The element at index k is (start of top run + k) mod 16. Such a window reaching 16 or more phases sets `error`.
- R5: Runs compete in ascending order of their lowest phase, and a merged window takes the position of its top run. A later candidate replaces the current choice only when its count is strictly larger, so on a tie the earlier candidate wins.
- R6: A `start` raised while a mask is being processed is ignored. It produces no extra `done` and does not change the pending result.
- R7: After reset, `done`, `error` and `phase` are all 0.
- R8: `phase` and `error` change only in the cycle in which `done` is high, and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Accept `mask` and begin a selection (idle only) |
| mask | input | NPH (16) | Pass mask, bit n set when phase n passed |
| done | output | 1 | One-cycle pulse marking a new result |
| phase | output | log2(NPH) (4) | Selected phase, 0 on error |
| error | output | 1 | Selection failed (no passing phase) |

## Verification
Single set bits at either end and a full mask check the three-quarter index arithmetic at its extremes. Isolated runs that touch only phase 0 or only phase 15 check that no merge happens without both ends. Masks with bits at both ends check the merge. In those masks the merged window is sometimes the widest and sometimes only ties a middle run, and the result must wrap past phase 15. Equal-width runs confirm that the earliest candidate is kept, and a start raised in mid-scan with an empty mask confirms that it is ignored. A stream of pseudo-random masks is then compared against a model that builds the run lists explicitly.

// File: rtl/phase_window_pick.sv
module phase_window_pick #(
  parameter int NPH = 16,
  localparam int PW = $clog2(NPH),
  localparam int CW = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NPH-1:0] mask,
  output logic          done,
  output logic [PW-1:0] phase,
  output logic          error
);

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_FIN} st_t;

  st_t            st;
  logic [NPH-1:0] m_q;
  logic [PW-1:0]  p;
  logic           in_run;
  logic [PW-1:0]  cur_s, mid_s;
  logic [CW-1:0]  cur_c, mid_c, c0;

  logic           bit_now, all_one, wrap, err_w;
  logic [CW-1:0]  merged, sel_c;
  logic [PW-1:0]  sel_s, pick_w;
  logic [CW+1:0]  triple, quart, idx;

  assign bit_now = m_q[p];
  assign all_one = in_run && (cur_s == '0);
  assign wrap    = m_q[0] && m_q[NPH-1] && !all_one;
  assign merged  = cur_c + c0;

  always_comb begin
    sel_s = '0;
    sel_c = c0;
    if (!wrap) begin
      if (mid_c > sel_c) begin
        sel_s = mid_s;
        sel_c = mid_c;
      end
      if (in_run && (cur_c > sel_c)) begin
        sel_s = cur_s;
        sel_c = cur_c;
      end
    end else begin
      sel_s = mid_s;
      sel_c = mid_c;
      if (merged > mid_c) begin
        sel_s = cur_s;
        sel_c = merged;
      end
    end
  end

  assign triple = {2'b00, sel_c} * (CW+2)'(3);
  assign quart  = triple >> 2;
  assign idx    = (quart == '0) ? '0 : quart - (CW+2)'(1);
  assign pick_w = PW'((CW+2)'(sel_s) + idx);
  assign err_w  = (m_q == '0) || (wrap && (merged >= CW'(NPH)));

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      m_q    <= '0;
      p      <= '0;
      in_run <= 1'b0;
      cur_s  <= '0;
      cur_c  <= '0;
      mid_s  <= '0;
      mid_c  <= '0;
      c0     <= '0;
      done   <= 1'b0;
      phase  <= '0;
      error  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          m_q    <= mask;
          p      <= '0;
          in_run <= 1'b0;
          cur_s  <= '0;
          cur_c  <= '0;
          mid_s  <= '0;
          mid_c  <= '0;
          c0     <= '0;
          st     <= S_SCAN;
        end
        S_SCAN: begin
          if (bit_now) begin
            if (!in_run) begin
              cur_s  <= p;
              cur_c  <= CW'(1);
              in_run <= 1'b1;
            end else begin
              cur_c <= cur_c + CW'(1);
            end
          end else if (in_run) begin
            in_run <= 1'b0;
            if (cur_s == '0) begin
              c0 <= cur_c;
            end else if (cur_c > mid_c) begin
              mid_c <= cur_c;
              mid_s <= cur_s;
            end
          end
          if (p == PW'(NPH-1)) st <= S_FIN;
          else p <= p + PW'(1);
        end
        S_FIN: begin
          done  <= 1'b1;
          phase <= err_w ? '0 : pick_w;
          error <= err_w;
          st    <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/phase_window_pick_chk.sv
module phase_window_pick_chk #(
  parameter int NPH = 16,
  localparam int PW = $clog2(NPH),
  localparam int LAT = NPH + 1,
  localparam int KW = $clog2(LAT + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          done,
  input logic [PW-1:0] phase,
  input logic          error
);

  logic [KW-1:0] cnt;
  logic          due;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      due <= 1'b0;
    end else begin
      due <= (cnt == KW'(1));
      if (cnt == '0) begin
        if (start) cnt <= KW'(LAT);
      end else begin
        cnt <= cnt - KW'(1);
      end
    end
  end

  a_r1_done_on_time: assert property (@(posedge clk) disable iff (rst) done == due);
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  a_r8_hold:         assert property (@(posedge clk) disable iff (rst) !done |-> ($stable(phase) && $stable(error)));
  a_r2_err_phase:    assert property (@(posedge clk) disable iff (rst) error |-> (phase == '0));
  a_r7_reset_state:  assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (!done && !error && phase == '0));

endmodule

bind phase_window_pick phase_window_pick_chk #(.NPH(NPH)) i_chk (
  .clk(clk), .rst(rst), .start(start), .done(done), .phase(phase), .error(error)
);

// File: tb/test_phase_window_pick.sv
module test_phase_window_pick;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] mask = '0;
  logic        done;
  logic [3:0]  phase;
  logic        error;

  int n_chk = 0;
  int n_bad = 0;
  int ncyc = 0;
  int extra_done = 0;
  bit finished = 0;

  logic [36:0] q_exp[$];
  string       q_tag[$];
  logic [4:0]  last_res;

  always #2.5 clk = ~clk;

  phase_window_pick #(.NPH(16)) i_phase_window_pick (
    .clk(clk), .rst(rst), .start(start), .mask(mask),
    .done(done), .phase(phase), .error(error)
  );

  function automatic logic [4:0] ref_pick(logic [15:0] m);
    int el[16][16];
    int rc[16];
    int nr, prev, tot, best, bc, k, v;
    for (int a = 0; a < 16; a++) begin
      rc[a] = 0;
      for (int b = 0; b < 16; b++) el[a][b] = 0;
    end
    nr = -1;
    prev = -2;
    for (int ph = 0; ph < 16; ph++) begin
      if (m[ph]) begin
        if (ph != prev + 1) nr++;
        el[nr][rc[nr]] = ph;
        rc[nr]++;
        prev = ph;
      end
    end
    if (nr < 0) return 5'b1_0000;
    if (nr > 0 && el[0][0] == 0 && el[nr][rc[nr]-1] == 15) begin
      tot = rc[0] + rc[nr];
      if (tot >= 16) return 5'b1_0000;
      for (int b = 0; b < rc[0]; b++) el[nr][rc[nr]+b] = el[0][b];
      rc[nr] = tot;
      rc[0] = 0;
    end
    best = 0;
    bc = 0;
    for (int a = 0; a <= nr; a++) begin
      if (rc[a] > bc) begin
        bc = rc[a];
        best = a;
      end
    end
    k = (bc * 3) / 4;
    if (k != 0) k--;
    v = el[best][k];
    if (v > 15) return 5'b1_0000;
    return {1'b0, 4'(v)};
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_mask(logic [15:0] m, string tag);
    @(negedge clk);
    #1;
    q_exp.push_back({32'(ncyc + 18), ref_pick(m)});
    q_tag.push_back(tag);
    start = 1'b1;
    mask = m;
    @(negedge clk);
    #1;
    start = 1'b0;
    while (q_exp.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  always @(negedge clk) begin
    ncyc = ncyc + 1;
    if (!rst && done) begin
      if (q_exp.size() == 0) begin
        extra_done++;
        check(0, "R6 unexpected done", 1, 0);
      end else begin
        logic [36:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        check(ncyc == int'(e[36:5]), "R1 latency", ncyc, int'(e[36:5]));
        check({error, phase} == e[4:0], t, int'({error, phase}), int'(e[4:0]));
        last_res = e[4:0];
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R7 done", int'(done), 0);
    check(error == 1'b0, "R7 error", int'(error), 0);
    check(phase == 4'd0, "R7 phase", int'(phase), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    run_mask(16'h0000, "R2 empty");
    run_mask(16'hFFFF, "R3 full");
    run_mask(16'h0001, "R3 single low");
    run_mask(16'h8000, "R3 single high");
    run_mask(16'h00F0, "R3 middle four");
    run_mask(16'h000F, "R4 low run no wrap");
    run_mask(16'hF000, "R4 high run no wrap");
    run_mask(16'hC003, "R4 wrap small");
    run_mask(16'hE01F, "R4 wrap widest");
    run_mask(16'h0F0F, "R5 tie earliest");
    run_mask(16'h8181, "R5 tie wrap vs middle");
    run_mask(16'h3F01, "R5 later strictly wider");

    repeat (6) @(negedge clk);
    check(phase == last_res[3:0] && error == last_res[4], "R8 hold",
          int'({error, phase}), int'(last_res));

    @(negedge clk);
    #1;
    q_exp.push_back({32'(ncyc + 18), ref_pick(16'h07E0)});
    q_tag.push_back("R6 pending result");
    start = 1'b1;
    mask = 16'h07E0;
    @(negedge clk);
    #1;
    start = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    start = 1'b1;
    mask = 16'h0000;
    @(negedge clk);
    #1;
    start = 1'b0;
    repeat (30) @(negedge clk);
    check(q_exp.size() == 0 && extra_done == 0, "R6 ignored start",
          extra_done + q_exp.size(), 0);

    lf = 16'hACE1;
    for (int n = 0; n < 24; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      run_mask(lf & {lf[7:0], lf[15:8]}, "R3 random");
    end

    finished = 1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule